// File: doc/BRIEF.md
# I2C Bus Clear Recovery Sequencer

This block frees an I2C bus when a target device is holding SDA low because it stopped partway through a byte. After one start pulse the block runs a fixed recovery sequence. First it releases both lines for one half-period. With SDA released, this gives a not-acknowledge. Next it clocks SCL nine times, which lets the target shift out whatever it was sending. Last it builds a STOP condition: SDA goes low while SCL is low, SCL is released, and then SDA is released.

Both outputs are open-drain enables. A high output means the block pulls that line low. The sampled levels of SCL and SDA come back in as inputs. The half-period is given in system clocks and is latched at start. A request of zero selects a built-in 20 microsecond default, derived from the clock-frequency parameter.

While SCL is released during a high phase, a target may stretch the clock by holding SCL low. The high phase then lasts longer, and the block counts only the cycles in which SCL is actually seen high.

The block has no say in when recovery is needed. A surrounding controller decides that, raises the start pulse, and reads the status bit once the done pulse appears.

Top module: `i2c_bus_clear`

## Requirements
- R1: A sequence has the following timeline in half-periods H (no stretching), counting cycle 1 as the first cycle after the start pulse is sampled:
  - cycles 1..H: both lines released;
  - then nine pulses, each with SCL driven low for H cycles and then released for H cycles;
  - then SCL driven low for H cycles as the STOP setup;
  - then SCL released for H cycles.
- R2: H is taken from `half_period_i` at the cycle the start pulse is accepted. A value of 0 selects CLK_HZ/50000 clocks (20 us). A value of 1 is raised to 2.
- R3: SDA is not driven during the first half-period or during any of the nine pulses.
- R4: SDA is driven low from the second cycle of the STOP setup phase until the end of the final released-SCL phase. It is released in cycle 21H+1.
- R5: `sda_drive_low_o` only becomes active in a cycle in which `scl_drive_low_o` is active.
- R6: A start pulse that arrives while a sequence is running is ignored, including the half-period value presented with it.
- R7: `busy_o` is high from cycle 1 through the done cycle and low otherwise.
- R8: `done_o` is high for exactly one cycle, cycle 21H+1, with both line enables inactive in that cycle.
- R9: `sda_ok_o` takes the SDA level sampled in the done cycle and holds it until the next done cycle. It is 0 after reset.
- R10: In a released-SCL phase (pulse high or STOP), a cycle in which SCL is sampled low does not count. Each such cycle lengthens the phase and delays the rest of the sequence by one cycle.
- R11: After reset, neither line is driven and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run one recovery sequence |
| half_period_i | input | CNT_W | Half-period in clocks; 0 selects the 20 us default |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_drive_low_o | output | 1 | Open-drain enable: pull SCL low |
| sda_drive_low_o | output | 1 | Open-drain enable: pull SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence finishes |
| sda_ok_o | output | 1 | SDA level seen at the end of the last sequence |

## Verification
The line enables are decoded straight from the phase state, the phase timer and the pulse counter, so internal faults appear at the ports:
- A wrong phase state changes an enable in the very next cycle.
- A timer off by one moves every later edge by one cycle per half-period.
- A pulse counter off by one adds or removes a full 2H window of SCL activity just before the STOP.

Comparing the enables on every cycle against an arithmetic timeline catches all of these within the sequence in which they occur. A stale status bit shows up on the first cycle after done.

// File: rtl/i2c_bclr_pkg.sv
package i2c_bclr_pkg;

    typedef enum logic [2:0] {
        BC_IDLE      = 3'd0,
        BC_NACK      = 3'd1,
        BC_LOW       = 3'd2,
        BC_HIGH      = 3'd3,
        BC_STOP_LOW  = 3'd4,
        BC_STOP_HIGH = 3'd5,
        BC_FIN       = 3'd6
    } bc_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } bc_drive_t;

    // Minimum usable half-period: the STOP needs one cycle of SCL low before SDA falls.
    localparam int unsigned BC_MIN_HALF = 2;

    function automatic logic [31:0] bc_pick_half(input logic [31:0] req,
                                                 input logic [31:0] dflt);
        if (req == 32'd0)
            return dflt;
        if (req < BC_MIN_HALF)
            return BC_MIN_HALF;
        return req;
    endfunction

    function automatic logic bc_is_released_phase(input bc_state_e s);
        return (s == BC_HIGH) || (s == BC_STOP_HIGH);
    endfunction

endpackage

// File: rtl/bclr_phase_timer.sv
module bclr_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             advance_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o,
    output logic             first_o
);
    logic [CNT_W-1:0] tick_q;

    assign expire_o = advance_i && (tick_q == (limit_i - CNT_W'(1)));
    assign first_o  = (tick_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            tick_q <= '0;
        else if (expire_o)
            tick_q <= '0;
        else if (advance_i)
            tick_q <= tick_q + CNT_W'(1);
    end
endmodule

// File: rtl/bclr_pulse_counter.sv
module bclr_pulse_counter #(
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic incr_i,
    output logic last_o
);
    localparam int PW = $clog2(NUM_PULSES + 1);

    logic [PW-1:0] done_q;

    assign last_o = (done_q == PW'(NUM_PULSES - 1));

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            done_q <= '0;
        else if (incr_i)
            done_q <= done_q + PW'(1);
    end
endmodule

// File: rtl/bclr_fsm.sv
module bclr_fsm
    import i2c_bclr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      expire_i,
    input  logic      last_pulse_i,
    output bc_state_e state_o,
    output logic      accept_o,
    output logic      pulse_done_o
);
    bc_state_e state_q, state_d;

    assign state_o      = state_q;
    assign accept_o     = (state_q == BC_IDLE) && start_i;
    assign pulse_done_o = (state_q == BC_HIGH) && expire_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BC_IDLE:      if (start_i)  state_d = BC_NACK;
            BC_NACK:      if (expire_i) state_d = BC_LOW;
            BC_LOW:       if (expire_i) state_d = BC_HIGH;
            BC_HIGH:      if (expire_i) state_d = last_pulse_i ? BC_STOP_LOW : BC_LOW;
            BC_STOP_LOW:  if (expire_i) state_d = BC_STOP_HIGH;
            BC_STOP_HIGH: if (expire_i) state_d = BC_FIN;
            BC_FIN:                     state_d = BC_IDLE;
            default:                    state_d = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= BC_IDLE;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
    import i2c_bclr_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int CNT_W      = 16,
    parameter int NUM_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] half_period_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_drive_low_o,
    output logic             sda_drive_low_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sda_ok_o
);
    localparam int DEFAULT_HALF = CLK_HZ / 50_000;

    bc_state_e        state;
    bc_drive_t        drive;
    logic             accept, pulse_done, last_pulse;
    logic             expire, first_tick, advance;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] half_eff;
    logic             sda_ok_q;

    assign half_eff = CNT_W'(bc_pick_half(32'(half_period_i), 32'(DEFAULT_HALF)));

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= CNT_W'(BC_MIN_HALF);
        else if (accept)
            half_q <= half_eff;
    end

    // A released phase only advances while the line is really high (stretching).
    assign advance = bc_is_released_phase(state) ? scl_i : 1'b1;

    bclr_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .expire_i     (expire),
        .last_pulse_i (last_pulse),
        .state_o      (state),
        .accept_o     (accept),
        .pulse_done_o (pulse_done)
    );

    bclr_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (state == BC_IDLE || state == BC_FIN),
        .advance_i (advance),
        .limit_i   (half_q),
        .expire_o  (expire),
        .first_o   (first_tick)
    );

    bclr_pulse_counter #(.NUM_PULSES(NUM_PULSES)) u_pulses (
        .clk     (clk),
        .rst     (rst),
        .clear_i (state == BC_IDLE),
        .incr_i  (pulse_done),
        .last_o  (last_pulse)
    );

    always_comb begin
        drive.scl_low = (state == BC_LOW) || (state == BC_STOP_LOW);
        drive.sda_low = ((state == BC_STOP_LOW) && !first_tick) || (state == BC_STOP_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sda_ok_q <= 1'b0;
        else if (state == BC_FIN)
            sda_ok_q <= sda_i;
    end

    assign scl_drive_low_o = drive.scl_low;
    assign sda_drive_low_o = drive.sda_low;
    assign busy_o          = (state != BC_IDLE);
    assign done_o          = (state == BC_FIN);
    assign sda_ok_o        = sda_ok_q;
endmodule

// File: rtl/bclr_checker.sv
module bclr_checker (
    input logic clk,
    input logic rst,
    input logic scl_drive_low_o,
    input logic sda_drive_low_o,
    input logic busy_o,
    input logic done_o,
    input logic sda_ok_o
);
    assert_sda_falls_under_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low_o) |-> scl_drive_low_o);

    assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_lines_released_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!scl_drive_low_o && !sda_drive_low_o && busy_o));

    assert_idle_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_drive_low_o && !sda_drive_low_o));

    assert_busy_ends_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(done_o));

    assert_status_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(done_o) |-> $stable(sda_ok_o));
endmodule

bind i2c_bus_clear bclr_checker u_bclr_checker (
    .clk             (clk),
    .rst             (rst),
    .scl_drive_low_o (scl_drive_low_o),
    .sda_drive_low_o (sda_drive_low_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .sda_ok_o        (sda_ok_o)
);

// File: tb/i2c_bus_clear_bench.sv
`timescale 1ns/1ps
module i2c_bus_clear_bench;
    localparam int CW     = 16;
    localparam int CLK_HZ = 200_000_000;
    localparam int DEF_H  = CLK_HZ / 50_000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] half_period_i = '0;
    logic          stretch_hold = 1'b0;
    logic          sda_stuck = 1'b0;
    logic          scl_drive_low_o, sda_drive_low_o, busy_o, done_o, sda_ok_o;
    logic          scl_i, sda_i;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign scl_i = !scl_drive_low_o && !stretch_hold;
    assign sda_i = !sda_drive_low_o && !sda_stuck;

    i2c_bus_clear #(.CLK_HZ(CLK_HZ), .CNT_W(CW), .NUM_PULSES(9)) u_i2c_bus_clear (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .half_period_i   (half_period_i),
        .scl_i           (scl_i),
        .sda_i           (sda_i),
        .scl_drive_low_o (scl_drive_low_o),
        .sda_drive_low_o (sda_drive_low_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .sda_ok_o        (sda_ok_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Timeline without stretching, cycle kk counted from 1.
    function automatic bit e_scl(input int kk, input int h);
        int r;
        if (kk <= h) return 0;
        if (kk <= 19 * h) begin
            r = (kk - h - 1) % (2 * h);
            return r < h;
        end
        if (kk <= 20 * h) return 1;
        return 0;
    endfunction

    function automatic bit e_sda(input int kk, input int h);
        return (kk >= 19 * h + 2) && (kk <= 21 * h);
    endfunction

    task automatic run_seq(input int h_in, input int h, input int sp, input int sl,
                           input bit stuck, input bit restart, input string scl_req);
        int total, hs, kk;
        int bad_scl, bad_sda_pre, bad_sda_stop, bad_busy, bad_done, bad_rise;
        bit prev_sda, e_s, e_d, in_win;
        bad_scl = 0; bad_sda_pre = 0; bad_sda_stop = 0;
        bad_busy = 0; bad_done = 0; bad_rise = 0;
        prev_sda = 0;
        total = 21 * h + sl;
        hs = 2 * h * (sp + 1) + 1;
        sda_stuck = stuck;
        @(negedge clk);
        start_i = 1'b1;
        half_period_i = CW'(h_in);
        @(negedge clk);
        for (int k = 1; k <= total + 2; k++) begin
            if (k == 1) start_i = 1'b0;
            in_win = (sl > 0) && (k >= hs) && (k < hs + sl);
            kk = (sl > 0 && k >= hs + sl) ? k - sl : k;
            if (in_win) begin
                e_s = 0; e_d = 0;
            end else begin
                e_s = e_scl(kk, h); e_d = e_sda(kk, h);
            end
            if (k > total + 1) begin e_s = 0; e_d = 0; end
            if (scl_drive_low_o !== e_s) bad_scl++;
            if (sda_drive_low_o !== e_d) begin
                if (kk <= 19 * h) bad_sda_pre++; else bad_sda_stop++;
            end
            if (busy_o !== (k <= total + 1)) bad_busy++;
            if (done_o !== (k == total + 1)) bad_done++;
            if (sda_drive_low_o && !prev_sda && !scl_drive_low_o) bad_rise++;
            prev_sda = sda_drive_low_o;
            if (k == total + 2)
                chk(sda_ok_o == !stuck, "R9", "status after done", sda_ok_o, !stuck);
            stretch_hold = in_win;
            if (restart && k == 5) begin
                start_i = 1'b1;
                half_period_i = CW'(h_in + 3);
            end
            if (restart && k == 6) start_i = 1'b0;
            @(negedge clk);
        end
        stretch_hold = 1'b0;
        chk(bad_scl == 0, scl_req, "SCL timeline mismatches", bad_scl, 0);
        chk(bad_sda_pre == 0, "R3", "SDA driven before STOP", bad_sda_pre, 0);
        chk(bad_sda_stop == 0, "R4", "STOP SDA mismatches", bad_sda_stop, 0);
        chk(bad_rise == 0, "R5", "SDA fell with SCL released", bad_rise, 0);
        chk(bad_busy == 0, "R7", "busy mismatches", bad_busy, 0);
        chk(bad_done == 0, "R8", "done mismatches", bad_done, 0);
        sda_stuck = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!scl_drive_low_o && !sda_drive_low_o, "R11", "lines after reset",
            {scl_drive_low_o, sda_drive_low_o}, 0);
        chk(!busy_o && !done_o, "R11", "busy/done after reset", {busy_o, done_o}, 0);
        chk(!sda_ok_o, "R9", "status after reset", sda_ok_o, 0);
        // R1 R2 sweep over half-periods, 1 raised to 2
        for (int hv = 1; hv <= 7; hv++)
            run_seq(hv, (hv < 2) ? 2 : hv, 0, 0, 0, 0, "R1 R2");
        // R6 restart ignored
        run_seq(4, 4, 0, 0, 0, 1, "R6");
        // R10 stretching on different pulses
        run_seq(3, 3, 0, 5, 0, 0, "R10");
        run_seq(5, 5, 8, 2, 0, 0, "R10");
        // R9 stuck SDA gives low status
        run_seq(3, 3, 0, 0, 1, 0, "R1 R9");
        // R2 default half-period of 20 us
        run_seq(0, DEF_H, 0, 0, 0, 0, "R2");
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule